// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Access Rights

This block holds a small set of page translations for a 32-bit virtual address space with 4 KB pages. Each lookup compares the page number and the current process identifier against every stored entry at once. A match yields the physical frame, and that frame joined with the untouched 12-bit page offset forms the physical address. Because every entry carries a process tag, translations from different tasks can live side by side, so nothing has to be flushed on a task switch. When no entry matches, the block raises a miss fault. Software then walks the page tables and installs the translation.

Each entry has read and write rights, a touched bit and a dirty bit. The touched bit is set by any hit and feeds an approximate least-recently-used victim choice. A single command clears every touched bit at once, for the periodic epoch update. The dirty bit is set by a permitted write, so that pages never written need not be copied back. Fill and invalidate commands only take effect in privileged mode. The same command from user mode is rejected and reported.

All lookup results are registered. They appear one cycle after the request.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup whose page number (address bits 31:12) and process ID both match a valid entry reports `rsp_hit`=1 in the cycle after `req_valid`, with `rsp_paddr` = {frame, address bits 11:0} and `rsp_slot` = the index of that entry.
- R2: A lookup that matches no valid entry on both page number and process ID reports `rsp_miss`=1, `rsp_hit`=0 and `rsp_paddr`=0. An entry stored under another process ID does not match.
- R3: A read hit on an entry without read right, or a write hit (`req_write`=1) on an entry without write right, reports `rsp_perm`=1 together with `rsp_hit`=1.
- R4: Any hit, including one that takes a rights fault, sets the entry's touched bit. `rsp_touched` reports that bit as it stood before the access.
- R5: A write hit that has write right sets the entry's dirty bit. A read, or a write refused for lack of rights, leaves it unchanged. `rsp_dirty` reports the bit as it stood before the access.
- R6: A command on `upd_valid` while `priv`=0 sets `upd_err`=1 in the next cycle and changes no entry.
- R7: A privileged invalidate (`upd_inval`=1) removes the entry that matches `upd_vpn` and `upd_pid`. Later lookups of that translation miss.
- R8: A privileged fill picks its entry in this order: an entry already holding the same page and process ID, then the lowest-indexed invalid entry, then the lowest-indexed entry with touched bit clear, otherwise entry 0. A filled entry starts with touched and dirty both clear.
- R9: `clr_touched` clears the touched bit of every entry in one cycle.
- R10: After reset every entry is invalid and every registered output is 0.
- R11: `rsp_valid` follows `req_valid` by one cycle, and exactly one of `rsp_hit` and `rsp_miss` is set whenever `rsp_valid` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_vaddr | input | 32 | Virtual address to translate |
| cur_pid | input | 8 | Process ID of the requester |
| priv | input | 1 | Privileged mode |
| upd_valid | input | 1 | Fill or invalidate command |
| upd_inval | input | 1 | 1 = invalidate, 0 = fill |
| upd_vpn | input | 20 | Page number of the command |
| upd_pid | input | 8 | Process ID of the command |
| upd_pfn | input | 20 | Frame number for a fill |
| upd_rd | input | 1 | Read right for a fill |
| upd_wr | input | 1 | Write right for a fill |
| clr_touched | input | 1 | Clear all touched bits |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Miss fault for software |
| rsp_perm | output | 1 | Rights fault |
| rsp_touched | output | 1 | Touched bit of the hit entry before the access |
| rsp_dirty | output | 1 | Dirty bit of the hit entry before the access |
| rsp_slot | output | 4 | Index of the hit entry |
| rsp_paddr | output | 32 | Translated physical address |
| upd_err | output | 1 | Command rejected in user mode |

## Verification
Every wrong internal bit reaches the ports one cycle after the next lookup that touches the entry. A corrupted tag or valid bit turns a hit into a miss, or the reverse. A wrong frame shows in the translated address. A stuck touched or dirty bit shows in the reported bits of the next hit. A wrong touched state also moves the slot that a later fill occupies, and that slot shows in `rsp_slot` on the lookup right after the fill.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [PID_W-1:0]           cur_pid,
  input  logic                       priv,
  input  logic                       upd_valid,
  input  logic                       upd_inval,
  input  logic [VA_W-OFF_W-1:0]      upd_vpn,
  input  logic [PID_W-1:0]           upd_pid,
  input  logic [PFN_W-1:0]           upd_pfn,
  input  logic                       upd_rd,
  input  logic                       upd_wr,
  input  logic                       clr_touched,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_miss,
  output logic                       rsp_perm,
  output logic                       rsp_touched,
  output logic                       rsp_dirty,
  output logic [$clog2(ENTRIES)-1:0] rsp_slot,
  output logic [PFN_W+OFF_W-1:0]     rsp_paddr,
  output logic                       upd_err
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] e_val, e_rd, e_wr, e_tch, e_drt;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PID_W-1:0]   e_pid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn [ENTRIES];

  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  assign lk_vpn = req_vaddr[VA_W-1:OFF_W];
  assign lk_off = req_vaddr[OFF_W-1:0];

  logic             lk_hit, um_hit, has_free, has_cold;
  logic [IDX_W-1:0] lk_idx, um_idx, free_idx, cold_idx, victim;

  always_comb begin
    lk_hit = 1'b0; lk_idx = '0;
    um_hit = 1'b0; um_idx = '0;
    has_free = 1'b0; free_idx = '0;
    has_cold = 1'b0; cold_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (e_val[i] && e_vpn[i] == lk_vpn && e_pid[i] == cur_pid) begin
        lk_hit = 1'b1; lk_idx = IDX_W'(i);
      end
      if (e_val[i] && e_vpn[i] == upd_vpn && e_pid[i] == upd_pid) begin
        um_hit = 1'b1; um_idx = IDX_W'(i);
      end
      if (!e_val[i]) begin
        has_free = 1'b1; free_idx = IDX_W'(i);
      end
      if (!e_tch[i]) begin
        has_cold = 1'b1; cold_idx = IDX_W'(i);
      end
    end
  end

  assign victim = um_hit   ? um_idx :
                  has_free ? free_idx :
                  has_cold ? cold_idx : '0;

  logic rights_ok, good_hit, do_upd, do_fill;
  assign rights_ok = req_write ? e_wr[lk_idx] : e_rd[lk_idx];
  assign good_hit  = req_valid && lk_hit;
  assign do_upd    = upd_valid && priv;
  assign do_fill   = do_upd && !upd_inval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_val <= '0;
      e_rd  <= '0;
      e_wr  <= '0;
      e_tch <= '0;
      e_drt <= '0;
    end else begin
      if (clr_touched) e_tch <= '0;
      if (good_hit) begin
        e_tch[lk_idx] <= 1'b1;
        if (req_write && e_wr[lk_idx]) e_drt[lk_idx] <= 1'b1;
      end
      if (do_upd && upd_inval && um_hit) e_val[um_idx] <= 1'b0;
      if (do_fill) begin
        e_val[victim] <= 1'b1;
        e_rd[victim]  <= upd_rd;
        e_wr[victim]  <= upd_wr;
        e_tch[victim] <= 1'b0;
        e_drt[victim] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      e_vpn[victim] <= upd_vpn;
      e_pid[victim] <= upd_pid;
      e_pfn[victim] <= upd_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_perm    <= 1'b0;
      rsp_touched <= 1'b0;
      rsp_dirty   <= 1'b0;
      rsp_slot    <= '0;
      rsp_paddr   <= '0;
      upd_err     <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= good_hit;
      rsp_miss    <= req_valid && !lk_hit;
      rsp_perm    <= good_hit && !rights_ok;
      rsp_touched <= good_hit && e_tch[lk_idx];
      rsp_dirty   <= good_hit && e_drt[lk_idx];
      rsp_slot    <= good_hit ? lk_idx : '0;
      rsp_paddr   <= good_hit ? {e_pfn[lk_idx], lk_off} : '0;
      upd_err     <= upd_valid && !priv;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic upd_valid,
  input logic priv,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_miss,
  input logic rsp_perm,
  input logic upd_err
);
  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  // R3
  perm_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perm |-> rsp_hit);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_perm));
  // R6
  user_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !priv) |=> upd_err);
  // R6
  priv_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && !priv) |=> !upd_err);
endmodule

bind tlb_xlate tlb_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .upd_valid(upd_valid),
  .priv(priv), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_perm(rsp_perm), .upd_err(upd_err)
);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  cur_pid = '0;
  logic        priv = 0, upd_valid = 0, upd_inval = 0, upd_rd = 0, upd_wr = 0, clr_touched = 0;
  logic [19:0] upd_vpn = '0, upd_pfn = '0;
  logic [7:0]  upd_pid = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_perm, rsp_touched, rsp_dirty, upd_err;
  logic [3:0]  rsp_slot;
  logic [31:0] rsp_paddr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tlb_xlate dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic look(input logic w, input logic [31:0] va, input logic [7:0] pid);
    @(negedge clk);
    req_valid = 1; req_write = w; req_vaddr = va; cur_pid = pid;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic upd(input logic p, input logic inv, input logic [19:0] vpn,
                     input logic [7:0] pid, input logic [19:0] pfn, input logic r, input logic w);
    @(negedge clk);
    priv = p; upd_valid = 1; upd_inval = inv; upd_vpn = vpn; upd_pid = pid;
    upd_pfn = pfn; upd_rd = r; upd_wr = w;
    @(posedge clk); #1;
    upd_valid = 0; priv = 0;
  endtask

  localparam int NV = 7;
  localparam logic        TV_W   [NV] = '{0, 0, 0, 1, 0, 1, 0};
  localparam logic [31:0] TV_VA  [NV] = '{32'h12345678, 32'h12345678, 32'h12345678,
                                          32'h00042010, 32'h00042010, 32'h12345FFF, 32'h12345000};
  localparam logic [7:0]  TV_PID [NV] = '{8'd1, 8'd2, 8'd3, 8'd1, 8'd1, 8'd1, 8'd1};
  localparam logic        TV_HIT [NV] = '{1, 1, 0, 1, 1, 1, 1};
  localparam logic        TV_PF  [NV] = '{0, 0, 0, 1, 0, 0, 0};
  localparam logic        TV_DRT [NV] = '{0, 0, 0, 0, 0, 0, 1};
  localparam logic [3:0]  TV_SL  [NV] = '{4'd0, 4'd2, 4'd0, 4'd1, 4'd1, 4'd0, 4'd0};
  localparam logic [31:0] TV_PA  [NV] = '{32'h00ABC678, 32'h00DEF678, 32'h0,
                                          32'h00777010, 32'h00777010, 32'h00ABCFFF, 32'h00ABC000};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 rsp_paddr", rsp_paddr, 0);
    chk("R10 upd_err", upd_err, 0);
    @(negedge clk) rst_n = 1;
    look(0, 32'h12345678, 8'd1);
    chk("R10 empty miss", rsp_miss, 1);
    chk("R11 rsp_valid", rsp_valid, 1);

    upd(1, 0, 20'h12345, 8'd1, 20'h00ABC, 1, 1);
    upd(1, 0, 20'h00042, 8'd1, 20'h00777, 1, 0);
    upd(1, 0, 20'h12345, 8'd2, 20'h00DEF, 1, 1);

    for (int i = 0; i < NV; i++) begin
      look(TV_W[i], TV_VA[i], TV_PID[i]);
      chk($sformatf("R1 hit v%0d", i), rsp_hit, TV_HIT[i]);
      chk($sformatf("R2 miss v%0d", i), rsp_miss, !TV_HIT[i]);
      chk($sformatf("R1 paddr v%0d", i), rsp_paddr, TV_PA[i]);
      chk($sformatf("R1 slot v%0d", i), rsp_slot, TV_SL[i]);
      chk($sformatf("R3 perm v%0d", i), rsp_perm, TV_PF[i]);
      chk($sformatf("R5 dirty v%0d", i), rsp_dirty, TV_DRT[i]);
    end
    // R4 touched seen on repeat hit
    look(0, 32'h12345000, 8'd1);
    chk("R4 touched", rsp_touched, 1);

    // R6 user fill rejected
    upd(0, 0, 20'h00099, 8'd1, 20'h00111, 1, 1);
    chk("R6 upd_err", upd_err, 1);
    look(0, 32'h00099000, 8'd1);
    chk("R6 no fill", rsp_miss, 1);
    upd(0, 1, 20'h00042, 8'd1, 20'h0, 0, 0);
    chk("R6 upd_err inval", upd_err, 1);
    look(0, 32'h00042000, 8'd1);
    chk("R6 no inval", rsp_hit, 1);

    // R7 privileged invalidate
    upd(1, 1, 20'h00042, 8'd1, 20'h0, 0, 0);
    chk("R6 no err priv", upd_err, 0);
    look(0, 32'h00042000, 8'd1);
    chk("R7 inval miss", rsp_miss, 1);

    // R8 free slot reuse
    upd(1, 0, 20'h00050, 8'd1, 20'h00055, 1, 1);
    look(0, 32'h00050004, 8'd1);
    chk("R8 free slot", rsp_slot, 1);
    chk("R8 fill clears touched", rsp_touched, 0);
    for (int i = 3; i < 16; i++) upd(1, 0, 20'(32'h100 + i), 8'd1, 20'(32'h200 + i), 1, 1);
    upd(1, 0, 20'h00060, 8'd1, 20'h00066, 1, 1);
    look(0, 32'h00060000, 8'd1);
    chk("R8 lowest untouched", rsp_slot, 3);
    for (int i = 4; i < 16; i++) look(0, {20'(32'h100 + i), 12'h0}, 8'd1);
    chk("R1 last entry slot", rsp_slot, 15);
    upd(1, 0, 20'h00070, 8'd1, 20'h00077, 1, 1);
    look(1, 32'h00070abc, 8'd1);
    chk("R8 all touched slot0", rsp_slot, 0);
    chk("R8 fill clears dirty", rsp_dirty, 0);
    upd(1, 0, 20'h00070, 8'd1, 20'h00088, 1, 1);
    look(0, 32'h00070abc, 8'd1);
    chk("R8 same tag refill slot", rsp_slot, 0);
    chk("R8 same tag refill pa", rsp_paddr, 32'h00088abc);
    look(0, 32'h12345000, 8'd1);
    chk("R8 evicted miss", rsp_miss, 1);

    // R9 clear touched
    look(0, 32'h12345000, 8'd2);
    chk("R9 before clear", rsp_touched, 1);
    @(negedge clk) clr_touched = 1;
    @(negedge clk) clr_touched = 0;
    look(0, 32'h12345000, 8'd2);
    chk("R9 after clear", rsp_touched, 0);

    // R5 refused write keeps dirty clear
    upd(1, 0, 20'h00080, 8'd1, 20'h00081, 1, 0);
    look(1, 32'h00080000, 8'd1);
    chk("R3 write no right", rsp_perm, 1);
    look(0, 32'h00080000, 8'd1);
    chk("R5 refused write not dirty", rsp_dirty, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule